// File: doc/BRIEF.md
# Sampled Cycle Counter With Register Port

This block keeps a free-running cycle count that advances on every clock and serves it to software through a narrow synchronous register port. Software cannot see the running count directly. It first writes a command word that latches the count into a holding register. It then reads that holding register as a low word and a high word. Both words come from the same clock edge, so the value is coherent even though each read is only one data-word wide.

The command word sits at the low-word offset. One bit clears the count and another bit latches it. When both bits are set in the same write, the latch takes the value from before the clear, and the count then starts again from zero. The port has an address, a write strobe with its data, and a read strobe. Read data is registered and appears on the cycle after the read strobe. Cycles without a read, and reads of unused offsets, return zero.

Top module: `cycle_snap_counter`

## Requirements
- R1: A synchronous active-high `rst` clears both the running count and the snapshot to zero, so that reads of either word return 0 after reset.
- R2: In every cycle without reset and without a clear command, the running count increases by one. It wraps to zero after its all-ones value.
- R3: A write to offset 0x14 with data bit 0 set makes the running count 0 after that edge. Each following clock then adds one to it.
- R4: A write to offset 0x14 with data bit 1 set copies into the snapshot the running count as it stood at that edge.
- R5: When data bits 0 and 1 are both set in one write, the snapshot receives the pre-clear count and the running count restarts from zero.
- R6: The following writes change neither the count nor the snapshot: a write to offset 0x14 with bits 0 and 1 both zero, whatever its other data bits are, and a write to any other offset.
- R7: A read of offset 0x14 returns snapshot bits 31:0 and a read of offset 0x18 returns snapshot bits 63:32. In both cases the data is on `reg_rdata` in the cycle after `reg_rd`. Bits above the count width read as zero.
- R8: A read of any offset other than 0x14 and 0x18 returns zero. `reg_rdata` is zero in every cycle that does not follow a read.
- R9: The snapshot holds its value until the next latch command or reset.
- R10: A read issued in the same cycle as a latch write returns the snapshot value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W (8) | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | DATA_W (32) | Registered read data, valid the cycle after `reg_rd` |

## Verification
On every cycle the assertions check the following:
- the one-per-clock increment and the clear;
- capture of the pre-edge count into the snapshot, and the snapshot holding when no latch is commanded;
- the one-cycle read path for both words, and zero data for idle cycles and unused offsets.

Some behaviour only shows up across a sequence of commands, so the bench scenarios cover it:
- the exact count after a clear followed by a known number of idle cycles;
- wrap-around, seen on a narrow 8-bit instance;
- that ignored writes leave the count running;
- that a read racing a latch sees the older value.

// File: rtl/csc_pkg.sv
package csc_pkg;

    typedef enum logic [1:0] {
        RSEL_NONE = 2'd0,
        RSEL_LO   = 2'd1,
        RSEL_HI   = 2'd2
    } csc_rsel_e;

    typedef struct packed {
        logic      clr;
        logic      snap;
        csc_rsel_e rsel;
    } csc_cmd_t;

endpackage

// File: rtl/csc_decode.sv
module csc_decode
    import csc_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = 32,
    parameter logic [ADDR_W-1:0] LO_OFS = 8'h14,
    parameter logic [ADDR_W-1:0] HI_OFS = 8'h18,
    parameter int unsigned CLR_BIT  = 0,
    parameter int unsigned SNAP_BIT = 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd,
    output csc_cmd_t          cmd
);

    localparam logic [DATA_W-1:0] CMD_MASK =
        (DATA_W'(1) << CLR_BIT) | (DATA_W'(1) << SNAP_BIT);

    logic hit_lo;
    logic hit_hi;
    logic unused_wdata;

    assign unused_wdata = ^(wdata & ~CMD_MASK);

    always_comb begin
        hit_lo   = (addr == LO_OFS);
        hit_hi   = (addr == HI_OFS);
        cmd.clr  = wr && hit_lo && wdata[CLR_BIT];
        cmd.snap = wr && hit_lo && wdata[SNAP_BIT];
        if (!rd)
            cmd.rsel = RSEL_NONE;
        else if (hit_lo)
            cmd.rsel = RSEL_LO;
        else if (hit_hi)
            cmd.rsel = RSEL_HI;
        else
            cmd.rsel = RSEL_NONE;
    end

endmodule

// File: rtl/csc_counter.sv
module csc_counter #(
    parameter int unsigned CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d;
    cnt_st_t st_q;

    always_comb begin
        st_d = st_q;
        if (clr)
            st_d.cnt = '0;
        else
            st_d.cnt = st_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign cnt = st_q.cnt;

endmodule

// File: rtl/csc_snapshot.sv
module csc_snapshot #(
    parameter int unsigned CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic [CNT_W-1:0] live,
    output logic [CNT_W-1:0] held
);

    typedef struct packed {
        logic [CNT_W-1:0] val;
    } snap_st_t;

    snap_st_t st_d;
    snap_st_t st_q;

    always_comb begin
        st_d = st_q;
        if (take)
            st_d.val = live;
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign held = st_q.val;

endmodule

// File: rtl/csc_readback.sv
module csc_readback
    import csc_pkg::*;
#(
    parameter int unsigned CNT_W  = 64,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  csc_rsel_e         rsel,
    input  logic [CNT_W-1:0]  held,
    output logic [DATA_W-1:0] rdata
);

    localparam int unsigned PAD_W = 2 * DATA_W;

    typedef struct packed {
        logic [DATA_W-1:0] data;
    } rb_st_t;

    rb_st_t            st_d;
    rb_st_t            st_q;
    logic [PAD_W-1:0]  wide;

    generate
        if (CNT_W == PAD_W) begin : g_full
            assign wide = held;
        end else begin : g_pad
            assign wide = {{(PAD_W - CNT_W){1'b0}}, held};
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        case (rsel)
            RSEL_LO: st_d.data = wide[DATA_W-1:0];
            RSEL_HI: st_d.data = wide[PAD_W-1:DATA_W];
            default: st_d.data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign rdata = st_q.data;

endmodule

// File: rtl/cycle_snap_counter.sv
module cycle_snap_counter
    import csc_pkg::*;
#(
    parameter int unsigned CNT_W    = 64,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] LO_OFS = 8'h14,
    parameter logic [ADDR_W-1:0] HI_OFS = 8'h18,
    parameter int unsigned CLR_BIT  = 0,
    parameter int unsigned SNAP_BIT = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_rd,
    output logic [DATA_W-1:0] reg_rdata
);

    csc_cmd_t         cmd;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] snap_q;

    csc_decode #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .LO_OFS  (LO_OFS),
        .HI_OFS  (HI_OFS),
        .CLR_BIT (CLR_BIT),
        .SNAP_BIT(SNAP_BIT)
    ) u_decode (
        .addr (reg_addr),
        .wr   (reg_wr),
        .wdata(reg_wdata),
        .rd   (reg_rd),
        .cmd  (cmd)
    );

    csc_counter #(.CNT_W(CNT_W)) u_counter (
        .clk(clk),
        .rst(rst),
        .clr(cmd.clr),
        .cnt(cnt_q)
    );

    csc_snapshot #(.CNT_W(CNT_W)) u_snapshot (
        .clk (clk),
        .rst (rst),
        .take(cmd.snap),
        .live(cnt_q),
        .held(snap_q)
    );

    csc_readback #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_readback (
        .clk  (clk),
        .rst  (rst),
        .rsel (cmd.rsel),
        .held (snap_q),
        .rdata(reg_rdata)
    );

endmodule

// File: rtl/csc_chk.sv
module csc_chk #(
    parameter int unsigned CNT_W    = 64,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] LO_OFS = 8'h14,
    parameter logic [ADDR_W-1:0] HI_OFS = 8'h18,
    parameter int unsigned CLR_BIT  = 0,
    parameter int unsigned SNAP_BIT = 1
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              reg_rd,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [CNT_W-1:0]  snap_q
);

    localparam int unsigned PAD_W = 2 * DATA_W;

    logic             w_clr;
    logic             w_snap;
    logic             r_lo;
    logic             r_hi;
    logic [PAD_W-1:0] snap_wide;

    assign w_clr     = reg_wr && (reg_addr == LO_OFS) && reg_wdata[CLR_BIT];
    assign w_snap    = reg_wr && (reg_addr == LO_OFS) && reg_wdata[SNAP_BIT];
    assign r_lo      = reg_rd && (reg_addr == LO_OFS);
    assign r_hi      = reg_rd && (reg_addr == HI_OFS);
    assign snap_wide = PAD_W'(snap_q);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (cnt_q == '0) && (snap_q == '0) && (reg_rdata == '0));

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        !w_clr |=> cnt_q == $past(cnt_q) + CNT_W'(1));

    // R3
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        w_clr |=> cnt_q == '0);

    // R4
    snap_capture_chk: assert property (@(posedge clk) disable iff (rst)
        w_snap |=> snap_q == $past(cnt_q));

    // R9
    snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !w_snap |=> $stable(snap_q));

    // R7
    read_lo_chk: assert property (@(posedge clk) disable iff (rst)
        r_lo |=> reg_rdata == $past(snap_wide[DATA_W-1:0]));

    // R7
    read_hi_chk: assert property (@(posedge clk) disable iff (rst)
        r_hi |=> reg_rdata == $past(snap_wide[PAD_W-1:DATA_W]));

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!r_lo && !r_hi) |=> reg_rdata == '0);

endmodule

bind cycle_snap_counter csc_chk #(
    .CNT_W   (CNT_W),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .LO_OFS  (LO_OFS),
    .HI_OFS  (HI_OFS),
    .CLR_BIT (CLR_BIT),
    .SNAP_BIT(SNAP_BIT)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_addr (reg_addr),
    .reg_wr   (reg_wr),
    .reg_wdata(reg_wdata),
    .reg_rd   (reg_rd),
    .reg_rdata(reg_rdata),
    .cnt_q    (cnt_q),
    .snap_q   (snap_q)
);

// File: tb/tb_cycle_snap_counter.sv
module tb_cycle_snap_counter;

    localparam logic [7:0] A_LO = 8'h14;
    localparam logic [7:0] A_HI = 8'h18;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        reg_rd = 1'b0;
    logic [31:0] rdata64;
    logic [31:0] rdata8;

    int n_cmp  = 0;
    int n_bad  = 0;
    bit done   = 1'b0;

    logic [63:0] m_cnt;
    logic [63:0] m_snap;

    always #4 clk = ~clk;

    cycle_snap_counter dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(rdata64)
    );

    cycle_snap_counter #(.CNT_W(8)) dut_w8 (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(rdata8)
    );

    // reference model of the requirements
    always @(posedge clk) begin
        if (rst) begin
            m_cnt  <= '0;
            m_snap <= '0;
        end else begin
            if (reg_wr && reg_addr == A_LO && reg_wdata[1]) m_snap <= m_cnt;
            if (reg_wr && reg_addr == A_LO && reg_wdata[0]) m_cnt <= '0;
            else m_cnt <= m_cnt + 64'd1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word64(input logic [7:0] a, input logic [63:0] s);
        if (a == A_LO) return s[31:0];
        if (a == A_HI) return s[63:32];
        return 32'd0;
    endfunction

    function automatic logic [31:0] word8(input logic [7:0] a, input logic [63:0] s);
        if (a == A_LO) return {24'd0, s[7:0]};
        return 32'd0;
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wcmd(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1; reg_rd = 1'b0;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rchk(input string req, input logic [7:0] a);
        logic [63:0] s;
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        s = m_snap;
        @(negedge clk);
        reg_rd = 1'b0;
        check(req, rdata64, word64(a, s));
        check({req, " w8"}, rdata8, word8(a, s));
    endtask

    task automatic snap_and_read(input string req);
        wcmd(A_LO, 32'h2);
        rchk(req, A_LO);
        rchk(req, A_HI);
    endtask

    initial begin
        #1600000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] held;
        idle(3);
        rst = 1'b0;
        // R1 reset state
        rchk("R1 reset lo", A_LO);
        rchk("R1 reset hi", A_HI);
        // R8 idle cycle after a read returns zero
        @(negedge clk);
        check("R8 idle", rdata64, 32'd0);

        // R3 exact count after clear, k idle edges
        for (int k = 0; k < 6; k++) begin
            wcmd(A_LO, 32'h1);
            idle(k);
            @(negedge clk);
            reg_addr = A_LO; reg_wdata = 32'h2; reg_wr = 1'b1;
            @(negedge clk);
            reg_wr = 1'b0;
            reg_rd = 1'b1;
            @(negedge clk);
            reg_rd = 1'b0;
            check("R3 count after clear", rdata64, 32'(k + 1));
        end

        // R2 R4 R7 sweep of capture points
        for (int n = 0; n < 48; n++) begin
            idle(n);
            snap_and_read("R4 R7 sweep");
        end

        // R2 wrap on the 8-bit instance
        idle(300);
        snap_and_read("R2 wrap");

        // R5 both bits in one write
        idle(7);
        wcmd(A_LO, 32'h3);
        rchk("R5 pre-clear value", A_LO);
        snap_and_read("R5 restart");

        // R6 ignored writes, R9 hold
        idle(20);
        snap_and_read("R6 base");
        held = m_snap;
        wcmd(A_LO, 32'hFFFF_FFFC);
        wcmd(A_HI, 32'h3);
        wcmd(8'h1C, 32'h3);
        rchk("R9 hold lo", A_LO);
        check("R9 hold model", m_snap[31:0], held[31:0]);
        snap_and_read("R6 still running");
        check("R6 not cleared", 32'(m_snap > held + 64'd5), 32'd1);

        // R8 unused offsets
        rchk("R8 unused 1C", 8'h1C);
        rchk("R8 unused 00", 8'h00);
        rchk("R8 unused 15", 8'h15);

        // R10 read racing a latch
        idle(9);
        @(negedge clk);
        held = m_snap;
        reg_addr = A_LO; reg_wdata = 32'h2; reg_wr = 1'b1; reg_rd = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0;
        check("R10 old value", rdata64, held[31:0]);
        rchk("R10 new value", A_LO);

        // R1 reset mid-run
        idle(5);
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        rchk("R1 after reset", A_LO);
        rchk("R1 after reset", A_HI);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule